// File: doc/BRIEF.md
# Power-Management Event and Timer Register Block

This block sits on a simple byte-addressed I/O bus and answers a 12-byte window starting at address 0x1F40. It holds a 16-bit event status register, a 16-bit event enable register and a free-running power-management counter. It drives one level-sensitive system control interrupt line. Software reads the status and enable pair as a single 32-bit word, or in byte or half-word pieces. It acknowledges events by writing ones to status bits. It arms or disarms interrupt sources by loading the enable bytes.

The counter advances on a tick-enable pulse that stands in for a 3.579545 MHz time base. Whenever its top bit changes, in either direction, the timer event status bit is raised. The power-button and global event status bits are raised by single-cycle pulses from outside. The control register that shares the window is not served here: accesses to it, and to any other unclaimed offset, are left to the bus default. Every request gets a response one clock later.

Top module: `pm1_event_timer`

## Requirements
- R1: After reset the status register, the enable register, the counter and the interrupt output are all zero.
- R2: The response comes one cycle after the request. Offsets 0 to 3 from base 0x1F40 (the status/enable word) and offset 8 (the counter) are claimed. Every other address, including offsets 4 to 7 and 9 to 11, is not claimed: the response returns read data 0 with the claim flag low, and no state changes.
- R3: Within the status/enable word, status sits in bits 15:0 and enable in bits 31:16. A read of 1, 2 or 4 bytes at offset k returns the word shifted right by 8*k and masked to the access width.
- R4: A written byte that lands on offset 0 or 1 clears each status bit written as 1 and keeps each status bit written as 0.
- R5: A written byte that lands on offset 2 or 3 is loaded into the enable register as written. Bytes that would land beyond offset 3 are dropped.
- R6: Status bit 0 is timer, bit 5 is power button and bit 8 is global. A set pulse on the power-button or global input raises its bit, and it wins over a same-cycle write-one-to-clear of that bit.
- R7: The interrupt output is high exactly when status AND enable AND 0x0121 is nonzero. It follows every status or enable change in the cycle after the change.
- R8: The counter (TMR_W bits, 32 by default) advances by one on each cycle with the tick input high, holds otherwise, and wraps to zero.
- R9: When the counter's top bit changes value, rising or falling, status bit 0 is set. This set wins over a same-cycle clear.
- R10: The counter accepts 4-byte reads only, returning its value zero-extended. A 4-byte write to it has no effect and no error.
- R11: A claimed access of unsupported width (not 1, 2 or 4 on the word, not 4 on the counter) raises the error flag, returns data 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_size | input | 3 | Access width in bytes |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| tick_en | input | 1 | Counter advance pulse |
| pwrbtn_set | input | 1 | Power-button event pulse |
| global_set | input | 1 | Global event pulse |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_claim | output | 1 | Request hit a served register |
| rsp_err | output | 1 | Unsupported access width |
| rsp_rdata | output | 32 | Read data |
| sci | output | 1 | System control interrupt level |

## Verification
A status bit can be raised and cleared in the same cycle: an external set pulse, or a counter top-bit flip, can coincide with a write-one-to-clear of that bit. The bench provokes this by driving the pulse, or the final tick of a flip, in the very cycle that carries the clearing write. It judges the result by reading the status back and by watching the interrupt line, which must stay high. The bench runs the counter with a narrow width so that both the rising and the falling flip of the top bit are reached.

// File: rtl/pm1_pkg.sv
package pm1_pkg;

  localparam logic [15:0] SCI_MASK = 16'h0121;
  localparam int unsigned BIT_TMR  = 0;
  localparam int unsigned BIT_PWR  = 5;
  localparam int unsigned BIT_GLB  = 8;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_EVT  = 2'd1,
    RGN_TMR  = 2'd2
  } region_e;

  // Lane mask for an access of 'size' bytes starting at byte 'off'
  function automatic logic [3:0] lane_mask(input logic [1:0] off, input logic [2:0] size);
    logic [3:0] m;
    for (int l = 0; l < 4; l++) begin
      m[l] = (l >= int'(off)) && (l < int'(off) + int'(size));
    end
    return m;
  endfunction

  // Read data for the status/enable word: shift down, mask to width
  function automatic logic [31:0] word_extract(input logic [31:0] word, input logic [1:0] off,
                                               input logic [2:0] size);
    logic [31:0] sh;
    logic [31:0] keep;
    sh = word >> (8 * off);
    case (size)
      3'd1:    keep = 32'h0000_00FF;
      3'd2:    keep = 32'h0000_FFFF;
      default: keep = 32'hFFFF_FFFF;
    endcase
    return sh & keep;
  endfunction

  function automatic logic evt_size_ok(input logic [2:0] size);
    return (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
  endfunction

endpackage

// File: rtl/pm1_decode.sv
module pm1_decode
  import pm1_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter logic [AW-1:0] BASE = 16'h1F40
) (
  input  logic          valid,
  input  logic [AW-1:0] addr,
  input  logic [2:0]    size,
  output region_e       region,
  output logic [1:0]    off,
  output logic          size_bad,
  output logic          acc_ok
);
  localparam logic [AW-1:0] EVT_SPAN = AW'(4);
  localparam logic [AW-1:0] TMR_OFF  = AW'(8);

  logic [AW-1:0] rel;

  always_comb begin
    rel    = addr - BASE;
    off    = rel[1:0];
    region = RGN_NONE;
    if (rel < EVT_SPAN)      region = RGN_EVT;
    else if (rel == TMR_OFF) region = RGN_TMR;
    case (region)
      RGN_EVT: size_bad = !evt_size_ok(size);
      RGN_TMR: size_bad = (size != 3'd4);
      default: size_bad = 1'b0;
    endcase
    acc_ok = valid && (region != RGN_NONE) && !size_bad;
  end
endmodule

// File: rtl/pm1_evt_regs.sv
module pm1_evt_regs
  import pm1_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stb,
  input  logic [3:0]  lanes,
  input  logic [31:0] wdata_al,
  input  logic        tmr_set,
  input  logic        pwr_set,
  input  logic        glb_set,
  output logic [15:0] sts,
  output logic [15:0] en
);
  logic [15:0] clr_bits;
  logic [15:0] set_bits;
  logic [15:0] en_next;

  // Status lanes: per-byte write-one-to-clear mask
  for (genvar b = 0; b < 2; b++) begin : g_sts_lane
    assign clr_bits[8*b +: 8] = (wr_stb && lanes[b]) ? wdata_al[8*b +: 8] : 8'h00;
  end

  // Enable lanes: direct byte load
  for (genvar b = 0; b < 2; b++) begin : g_en_lane
    assign en_next[8*b +: 8] = (wr_stb && lanes[b+2]) ? wdata_al[16 + 8*b +: 8] : en[8*b +: 8];
  end

  always_comb begin
    set_bits          = '0;
    set_bits[BIT_TMR] = tmr_set;
    set_bits[BIT_PWR] = pwr_set;
    set_bits[BIT_GLB] = glb_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts <= '0;
      en  <= '0;
    end else begin
      sts <= (sts & ~clr_bits) | set_bits;
      en  <= en_next;
    end
  end
endmodule

// File: rtl/pm1_timer.sv
module pm1_timer #(
  parameter int unsigned TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [TMR_W-1:0] cnt,
  output logic             msb_flip
);
  logic [TMR_W-1:0] cnt_next;

  always_comb begin
    cnt_next = tick ? cnt + TMR_W'(1) : cnt;
    msb_flip = cnt_next[TMR_W-1] ^ cnt[TMR_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_next;
  end
endmodule

// File: rtl/pm1_event_timer.sv
module pm1_event_timer
  import pm1_pkg::*;
#(
  parameter int unsigned TMR_W = 32,
  parameter logic [15:0] BASE  = 16'h1F40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [2:0]  req_size,
  input  logic [31:0] req_wdata,
  input  logic        tick_en,
  input  logic        pwrbtn_set,
  input  logic        global_set,
  output logic        rsp_valid,
  output logic        rsp_claim,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata,
  output logic        sci
);
  region_e           region;
  logic [1:0]        off;
  logic              size_bad;
  logic              acc_ok;
  logic              evt_wr;
  logic [3:0]        lanes;
  logic [31:0]       wdata_al;
  logic [15:0]       sts;
  logic [15:0]       en;
  logic [TMR_W-1:0]  cnt;
  logic              msb_flip;
  logic [31:0]       cnt_ext;
  logic [31:0]       rd_next;
  logic              bad_acc;

  pm1_decode #(.AW(16), .BASE(BASE)) u_dec (
    .valid(req_valid), .addr(req_addr), .size(req_size),
    .region(region), .off(off), .size_bad(size_bad), .acc_ok(acc_ok)
  );

  assign evt_wr   = acc_ok && req_write && (region == RGN_EVT);
  assign lanes    = lane_mask(off, req_size);
  assign wdata_al = req_wdata << (8 * off);
  assign bad_acc  = req_valid && (region != RGN_NONE) && size_bad;

  pm1_evt_regs u_evt (
    .clk(clk), .rst_n(rst_n), .wr_stb(evt_wr), .lanes(lanes), .wdata_al(wdata_al),
    .tmr_set(msb_flip), .pwr_set(pwrbtn_set), .glb_set(global_set),
    .sts(sts), .en(en)
  );

  pm1_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .cnt(cnt), .msb_flip(msb_flip)
  );

  assign cnt_ext = 32'(cnt);

  always_comb begin
    rd_next = '0;
    if (acc_ok && !req_write) begin
      if (region == RGN_EVT) rd_next = word_extract({en, sts}, off, req_size);
      else                   rd_next = cnt_ext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_claim <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_claim <= req_valid && (region != RGN_NONE);
      rsp_err   <= bad_acc;
      rsp_rdata <= rd_next;
    end
  end

  assign sci = |(sts & en & SCI_MASK);
endmodule

// File: rtl/pm1_checker.sv
module pm1_checker #(
  parameter int unsigned TMR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             pwrbtn_set,
  input logic             global_set,
  input logic             tick_en,
  input logic             bad_acc,
  input logic             msb_flip,
  input logic [15:0]      sts,
  input logic [15:0]      en,
  input logic [TMR_W-1:0] cnt,
  input logic             rsp_valid,
  input logic             rsp_claim,
  input logic             rsp_err,
  input logic [31:0]      rsp_rdata,
  input logic             sci
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_ERR_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_claim && rsp_rdata == 32'h0)); // R11
  AST_BAD_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |=> $stable(en)); // R11
  AST_PWR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pwrbtn_set |=> sts[5]); // R6
  AST_GLB_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    global_set |=> sts[8]); // R6
  AST_FLIP_SETS_TMR: assert property (@(posedge clk) disable iff (!rst_n)
    msb_flip |=> sts[0]); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> cnt == $past(cnt) + TMR_W'(1)); // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt)); // R8
  AST_SCI_ON_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrbtn_set && en[5] && !req_valid) |=> sci); // R7
endmodule

bind pm1_event_timer pm1_checker #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pwrbtn_set(pwrbtn_set),
  .global_set(global_set), .tick_en(tick_en), .bad_acc(bad_acc), .msb_flip(msb_flip),
  .sts(sts), .en(en), .cnt(cnt), .rsp_valid(rsp_valid), .rsp_claim(rsp_claim),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .sci(sci)
);

// File: tb/pm1_event_timer_test.sv
`timescale 1ns/1ps
module pm1_event_timer_test;
  localparam int unsigned TW = 10;
  localparam logic [15:0] B = 16'h1F40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic tick_en = 0, pwrbtn_set = 0, global_set = 0;
  logic rsp_valid, rsp_claim, rsp_err, sci;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pm1_event_timer #(.TMR_W(TW), .BASE(B)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .tick_en(tick_en), .pwrbtn_set(pwrbtn_set), .global_set(global_set),
    .rsp_valid(rsp_valid), .rsp_claim(rsp_claim), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .sci(sci)
  );

  // {write, offset, size, wdata, expected rdata, expected err}
  localparam logic [72:0] VEC [0:11] = '{
    {1'b1, 4'd2, 3'd2, 32'h0000_0121, 32'h0000_0000, 1'b0},
    {1'b0, 4'd0, 3'd4, 32'h0,         32'h0121_0000, 1'b0},
    {1'b0, 4'd3, 3'd1, 32'h0,         32'h0000_0001, 1'b0},
    {1'b0, 4'd3, 3'd2, 32'h0,         32'h0000_0001, 1'b0},
    {1'b1, 4'd0, 3'd4, 32'hFFFF_0000, 32'h0000_0000, 1'b0},
    {1'b0, 4'd2, 3'd2, 32'h0,         32'h0000_FFFF, 1'b0},
    {1'b1, 4'd0, 3'd3, 32'h0000_0000, 32'h0000_0000, 1'b1},
    {1'b0, 4'd0, 3'd4, 32'h0,         32'hFFFF_0000, 1'b0},
    {1'b1, 4'd2, 3'd1, 32'h0000_0000, 32'h0000_0000, 1'b0},
    {1'b0, 4'd0, 3'd4, 32'h0,         32'hFF00_0000, 1'b0},
    {1'b1, 4'd8, 3'd4, 32'h0000_1234, 32'h0000_0000, 1'b0},
    {1'b0, 4'd8, 3'd2, 32'h0,         32'h0000_0000, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [15:0] addr, input logic [2:0] sz,
                     input logic [31:0] d, input logic tk, input logic pw, input logic gl);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = d;
    tick_en = tk; pwrbtn_set = pw; global_set = gl;
    @(posedge clk);
    #1;
    req_valid = 0; req_write = 0; tick_en = 0; pwrbtn_set = 0; global_set = 0;
  endtask

  task automatic pulse(input logic tk, input logic pw, input logic gl);
    @(negedge clk);
    tick_en = tk; pwrbtn_set = pw; global_set = gl;
    @(posedge clk);
    #1;
    tick_en = 0; pwrbtn_set = 0; global_set = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) pulse(1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: reset state
    acc(0, B, 3'd4, 0, 0, 0, 0);
    check("R1 word", rsp_rdata, 32'h0);
    check("R1 sci", {31'b0, sci}, 32'h0);
    acc(0, B + 16'd8, 3'd4, 0, 0, 0, 0);
    check("R1 counter", rsp_rdata, 32'h0);
    check("R2 valid", {31'b0, rsp_valid}, 32'h1);

    // R3 R4 R5 R10 R11: vector table
    for (int v = 0; v < 12; v++) begin
      acc(VEC[v][72], B + 16'(VEC[v][71:68]), VEC[v][67:65], VEC[v][64:33], 0, 0, 0);
      check($sformatf("R3/R5/R10/R11 vec%0d data", v), rsp_rdata, VEC[v][32:1]);
      check($sformatf("R11 vec%0d err", v), {31'b0, rsp_err}, {31'b0, VEC[v][0]});
      check($sformatf("R2 vec%0d claim", v), {31'b0, rsp_claim}, 32'h1);
    end

    // R2: unclaimed offsets and outside window
    acc(1, B + 16'd4, 3'd4, 32'hFFFF_FFFF, 0, 0, 0);
    check("R2 ctl claim", {31'b0, rsp_claim}, 32'h0);
    acc(0, B + 16'd10, 3'd2, 0, 0, 0, 0);
    check("R2 off10 claim", {31'b0, rsp_claim}, 32'h0);
    acc(0, 16'h2000, 3'd4, 0, 0, 0, 0);
    check("R2 outside claim", {31'b0, rsp_claim}, 32'h0);
    check("R2 outside data", rsp_rdata, 32'h0);
    acc(0, B, 3'd4, 0, 0, 0, 0);
    check("R2 no state change", rsp_rdata, 32'hFF00_0000);

    // R5: bytes beyond offset 3 dropped
    acc(1, B + 16'd3, 3'd2, 32'h0000_AA21, 0, 0, 0);
    acc(0, B, 3'd4, 0, 0, 0, 0);
    check("R5 upper lane", rsp_rdata, 32'h2100_0000);

    // R6 R7: power button, mask
    acc(1, B + 16'd2, 3'd2, 32'h0000_FEDE, 0, 0, 0);
    pulse(0, 1, 1);
    acc(0, B, 3'd2, 0, 0, 0, 0);
    check("R6 status bits", rsp_rdata, 32'h0000_0120);
    check("R7 masked off", {31'b0, sci}, 32'h0);
    acc(1, B + 16'd3, 3'd1, 32'h0000_0001, 0, 0, 0);
    check("R7 global enable", {31'b0, sci}, 32'h1);
    acc(1, B + 16'd1, 3'd1, 32'h0000_0001, 0, 0, 0);
    check("R4 clear global", {31'b0, sci}, 32'h0);
    acc(0, B, 3'd2, 0, 0, 0, 0);
    check("R4 pwr kept", rsp_rdata, 32'h0000_0020);
    acc(1, B, 3'd1, 32'h0000_0020, 0, 1, 0);
    acc(0, B, 3'd2, 0, 0, 0, 0);
    check("R6 set wins", rsp_rdata, 32'h0000_0020);
    acc(1, B, 3'd4, 32'h0001_0020, 0, 0, 0);
    acc(0, B, 3'd4, 0, 0, 0, 0);
    check("R4 clear pwr", rsp_rdata, 32'h0001_0000);

    // R8 R9: counter and top-bit flips
    ticks(511);
    acc(0, B + 16'd8, 3'd4, 0, 0, 0, 0);
    check("R8 count", rsp_rdata, 32'd511);
    check("R9 no early flag", {31'b0, sci}, 32'h0);
    ticks(1);
    check("R9 rising flip sci", {31'b0, sci}, 32'h1);
    acc(1, B, 3'd1, 32'h0000_0001, 0, 0, 0);
    check("R7 clear drops sci", {31'b0, sci}, 32'h0);
    ticks(511);
    acc(0, B + 16'd8, 3'd4, 0, 0, 0, 0);
    check("R8 top", rsp_rdata, 32'd1023);
    ticks(1);
    acc(0, B + 16'd8, 3'd4, 0, 0, 0, 0);
    check("R8 wrap", rsp_rdata, 32'd0);
    check("R9 falling flip", {31'b0, sci}, 32'h1);
    acc(1, B, 3'd1, 32'h0000_0001, 0, 0, 0);
    ticks(511);
    acc(1, B, 3'd1, 32'h0000_0001, 1, 0, 0);
    check("R9 flip wins over clear", {31'b0, sci}, 32'h1);
    acc(0, B, 3'd2, 0, 0, 0, 0);
    check("R9 status bit0", rsp_rdata, 32'h0000_0001);

    // R10: counter write ignored
    acc(1, B + 16'd8, 3'd4, 32'h0000_0000, 0, 0, 0);
    acc(0, B + 16'd8, 3'd4, 0, 0, 0, 0);
    check("R10 write ignored", rsp_rdata, 32'd512);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule